// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is a general-purpose up-counting timer with a 32-bit register bus. A programmable prescaler divides the input clock. Each divided tick advances a main counter, which climbs to a programmable reload limit. On the tick after it reaches that limit, the counter returns to zero and an update event fires. An update event latches a sticky status flag. It also produces a one-cycle interrupt pulse, but only while both the counter-run bit and the update-interrupt-enable bit are set.

Software can force an update at any time through an event register. This restarts both the prescaler and the counter from zero. The counter value stays put when the divider or the reload limit is rewritten, and the next wrap is then reached from the current count.

Four compare registers are provided. The second of them (offset 0x38) drives a PWM output. Its compare value passes through a shadow copy that reloads only on update events. The output is driven only when the channel mode field selects the inverted PWM mode and both the preload bit and the channel-enable bit are set.

Top module: `tick_timer`

## Requirements
- R1: The counter advances once every (PRESC+1) clock cycles while CTRL bit 0 is set, and wraps from RELOAD to zero. The update period is therefore (PRESC+1)*(RELOAD+1) cycles. PRESC keeps only the low 16 bits of a write.
- R2: `irq` is high for exactly one cycle after an update event, and only when IEN bit 0 and CTRL bit 0 are both set.
- R3: While RELOAD is zero, the counter produces no update event, no flag and no interrupt.
- R4: STAT bit 0 is set by every update event. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R5: Writing EVGEN (0x14) with bit 0 set restarts the counter and the prescaler from zero and raises an update event. EVGEN always reads zero.
- R6: Writing PRESC or RELOAD leaves the counter value unchanged. The next wrap follows from the current count, RELOAD-COUNT+1 ticks later.
- R7: `pwm_out` is high when the count is at or above the active compare value of channel 2, and low below it. This holds only while CHMA[14:12] has bit 2 or bit 1 set with bit 0 clear, CHMA bit 11 is set and CHEN bit 4 is set; otherwise `pwm_out` is low.
- R8: A write to CMP channel 2 (0x38) reads back at once but reaches `pwm_out` only at the next update event.
- R9: After reset all registers read zero, the counter is zero, and `irq` and `pwm_out` are low.
- R10: The register offsets within the 16 KiB window are CTRL 0x00, CTRL2 0x04, SLAVE 0x08, IEN 0x0C, STAT 0x10, EVGEN 0x14, CHMA 0x18, CHMB 0x1C, CHEN 0x20, COUNT 0x24, PRESC 0x28, RELOAD 0x2C, CMP 0x34-0x40. Writes to other offsets change nothing, and reads of other offsets return zero.
- R11: COUNT is writable, and a written value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Update interrupt pulse |
| pwm_out | output | 1 | Channel 2 PWM output |

## Verification
The bench builds the timer with CNT_W=8 and the default 16-bit prescaler and four compare channels. The narrow counter keeps every wrap period short, so a full grid of four prescaler values against four reload values can be timed between interrupt pulses. It also puts compare values of zero and of one above the reload limit within a few cycles, together with all eight mode encodings of the PWM channel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W = 32;

  // word indices (byte offset / 4)
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_CTRL2  = 1;
  localparam int unsigned W_SLAVE  = 2;
  localparam int unsigned W_IEN    = 3;
  localparam int unsigned W_STAT   = 4;
  localparam int unsigned W_EVGEN  = 5;
  localparam int unsigned W_CHMA   = 6;
  localparam int unsigned W_CHMB   = 7;
  localparam int unsigned W_CHEN   = 8;
  localparam int unsigned W_COUNT  = 9;
  localparam int unsigned W_PRESC  = 10;
  localparam int unsigned W_RELOAD = 11;
  localparam int unsigned W_CMP0   = 13;

  // bit positions
  localparam int unsigned RUN_BIT      = 0;
  localparam int unsigned UPD_BIT      = 0;
  localparam int unsigned CH2_MODE_LSB = 12;
  localparam int unsigned CH2_PRE_BIT  = 11;
  localparam int unsigned CH2_OE_BIT   = 4;

  function automatic logic pwm_mode_ok(input logic [2:0] m);
    return (m[2] | m[1]) & ~m[0];
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    tick   = en && (pcnt_q >= div);
    pcnt_d = pcnt_q;
    if (clr)     pcnt_d = '0;
    else if (en) pcnt_d = tick ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             live, at_top;

  always_comb begin
    live   = (reload != '0);
    at_top = (cnt_q >= reload);
    wrap   = tick && live && at_top && !clr && !ld;
    cnt_d  = cnt_q;
    if (clr)               cnt_d = '0;
    else if (ld)           cnt_d = ld_val;
    else if (tick && live) cnt_d = at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [2:0]       mode,
  input  logic             preload,
  input  logic             outen,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] shadow,
  output logic             pwm
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] shadow_q, shadow_d;

  always_comb begin
    shadow_d = load ? cmp_in : shadow_q;
    pwm      = pwm_mode_ok(mode) && preload && outen && (cnt >= shadow_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  assign shadow = shadow_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              pwm_out
);
  import tmr_pkg::*;

  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned PWM_CH = 1;

  logic             rst_n;
  logic [IDX_W-1:0] word;
  logic             wr_en;
  logic             hit_ctrl, hit_ctrl2, hit_slave, hit_ien, hit_stat;
  logic             hit_chma, hit_chmb, hit_chen, hit_count, hit_presc, hit_reload;
  logic             ug, upd, tick, wrap, pwm_raw;
  logic [CNT_W-1:0] cnt, shadow;
  logic             unused_addr;

  logic [31:0]      ctrl_q, ctrl2_q, slave_q, ien_q, chma_q, chmb_q, chen_q;
  logic [PSC_W-1:0] presc_q;
  logic [CNT_W-1:0] reload_q;
  logic             uif_q, uif_d, irq_q, irq_d;
  logic [CNT_W-1:0] cmp_q [N_CMP];

  tmr_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_addr = ^bus_addr[1:0];
  assign wr_en       = bus_sel && bus_wr;

  always_comb begin
    hit_ctrl   = wr_en && (word == IDX_W'(W_CTRL));
    hit_ctrl2  = wr_en && (word == IDX_W'(W_CTRL2));
    hit_slave  = wr_en && (word == IDX_W'(W_SLAVE));
    hit_ien    = wr_en && (word == IDX_W'(W_IEN));
    hit_stat   = wr_en && (word == IDX_W'(W_STAT));
    hit_chma   = wr_en && (word == IDX_W'(W_CHMA));
    hit_chmb   = wr_en && (word == IDX_W'(W_CHMB));
    hit_chen   = wr_en && (word == IDX_W'(W_CHEN));
    hit_count  = wr_en && (word == IDX_W'(W_COUNT));
    hit_presc  = wr_en && (word == IDX_W'(W_PRESC));
    hit_reload = wr_en && (word == IDX_W'(W_RELOAD));
    ug         = wr_en && (word == IDX_W'(W_EVGEN)) && bus_wdata[UPD_BIT];
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[RUN_BIT]), .clr(ug),
    .div(presc_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(ug), .ld(hit_count),
    .ld_val(bus_wdata[CNT_W-1:0]), .reload(reload_q), .cnt(cnt), .wrap(wrap)
  );

  assign upd = wrap || ug;

  tmr_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .load(upd), .cmp_in(cmp_q[PWM_CH]),
    .mode(chma_q[CH2_MODE_LSB +: 3]), .preload(chma_q[CH2_PRE_BIT]),
    .outen(chen_q[CH2_OE_BIT]), .cnt(cnt), .shadow(shadow), .pwm(pwm_raw)
  );

  // next state of flag and interrupt
  always_comb begin
    irq_d = upd && ien_q[UPD_BIT] && ctrl_q[RUN_BIT];
    uif_d = uif_q;
    if (upd)           uif_d = 1'b1;
    else if (hit_stat) uif_d = uif_q & bus_wdata[UPD_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uif_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      uif_q <= uif_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ctrl2_q  <= '0;
      slave_q  <= '0;
      ien_q    <= '0;
      chma_q   <= '0;
      chmb_q   <= '0;
      chen_q   <= '0;
      presc_q  <= '0;
      reload_q <= '0;
    end else begin
      if (hit_ctrl)   ctrl_q   <= bus_wdata;
      if (hit_ctrl2)  ctrl2_q  <= bus_wdata;
      if (hit_slave)  slave_q  <= bus_wdata;
      if (hit_ien)    ien_q    <= bus_wdata;
      if (hit_chma)   chma_q   <= bus_wdata;
      if (hit_chmb)   chmb_q   <= bus_wdata;
      if (hit_chen)   chen_q   <= bus_wdata;
      if (hit_presc)  presc_q  <= bus_wdata[PSC_W-1:0];
      if (hit_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    logic hit;
    assign hit = wr_en && (word == IDX_W'(W_CMP0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cmp_q[g] <= '0;
      else if (hit) cmp_q[g] <= bus_wdata[CNT_W-1:0];
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (word)
        IDX_W'(W_CTRL):   bus_rdata = ctrl_q;
        IDX_W'(W_CTRL2):  bus_rdata = ctrl2_q;
        IDX_W'(W_SLAVE):  bus_rdata = slave_q;
        IDX_W'(W_IEN):    bus_rdata = ien_q;
        IDX_W'(W_STAT):   bus_rdata = BUS_W'(uif_q);
        IDX_W'(W_CHMA):   bus_rdata = chma_q;
        IDX_W'(W_CHMB):   bus_rdata = chmb_q;
        IDX_W'(W_CHEN):   bus_rdata = chen_q;
        IDX_W'(W_COUNT):  bus_rdata = BUS_W'(cnt);
        IDX_W'(W_PRESC):  bus_rdata = BUS_W'(presc_q);
        IDX_W'(W_RELOAD): bus_rdata = BUS_W'(reload_q);
        default:          bus_rdata = '0;
      endcase
      for (int k = 0; k < N_CMP; k++) begin
        if (word == IDX_W'(W_CMP0 + k)) bus_rdata = BUS_W'(cmp_q[k]);
      end
    end
  end

  assign irq     = irq_q;
  assign pwm_out = pwm_raw;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cen,
  input logic             uie,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr,
  input logic             wrap,
  input logic             ug,
  input logic             cnt_wr,
  input logic             uif,
  input logic             sr_wr,
  input logic             pwm,
  input logic             pe,
  input logic             ce,
  input logic [CNT_W-1:0] shadow,
  input logic             upd
);
  // R1: a stopped counter keeps its value
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !cnt_wr && !ug) |=> $stable(cnt));

  // R2: interrupt only follows a cycle with both enables set
  p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(uie && cen));

  // R3: zero reload never wraps
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr == '0) |-> !wrap);

  // R4: flag stays set until software writes the status register
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uif && !sr_wr) |=> uif);

  // R5: forced update zeroes the counter
  p_ug_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt == '0));

  // R7: output needs preload and channel enable
  p_pwm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |-> (pe && ce));

  // R8: active compare value moves only on update events
  p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(shadow));
endmodule

bind tick_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen(ctrl_q[0]), .uie(ien_q[0]), .irq(irq),
  .cnt(cnt), .arr(reload_q), .wrap(wrap), .ug(ug), .cnt_wr(hit_count),
  .uif(uif_q), .sr_wr(hit_stat), .pwm(pwm_out), .pe(chma_q[11]),
  .ce(chen_q[4]), .shadow(shadow), .upd(upd)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int unsigned CW = 8;

  localparam logic [13:0] A_CTRL   = 14'h00;
  localparam logic [13:0] A_IEN    = 14'h0C;
  localparam logic [13:0] A_STAT   = 14'h10;
  localparam logic [13:0] A_EVGEN  = 14'h14;
  localparam logic [13:0] A_CHMA   = 14'h18;
  localparam logic [13:0] A_CHEN   = 14'h20;
  localparam logic [13:0] A_COUNT  = 14'h24;
  localparam logic [13:0] A_PRESC  = 14'h28;
  localparam logic [13:0] A_RELOAD = 14'h2C;
  localparam logic [13:0] A_CMP2   = 14'h38;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(CW), .PSC_W(16), .N_CMP(4), .ADDR_W(14)) i_tick_timer (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic measure(output int per, output logic narrow);
    int guard = 0;
    per = 0; narrow = 1'b1;
    do begin @(negedge clk); guard++; end while (!irq && guard < 5000);
    @(negedge clk);
    if (irq) narrow = 1'b0;
    per = 1;
    while (!irq && per < 5000) begin @(negedge clk); per++; end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] d;
    int per;
    logic narrow;
    logic seen;

    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    rd(A_CTRL, d);   check("R9 ctrl", d, 0);
    rd(A_PRESC, d);  check("R9 presc", d, 0);
    rd(A_RELOAD, d); check("R9 reload", d, 0);
    rd(A_COUNT, d);  check("R9 count", d, 0);
    rd(A_CMP2, d);   check("R9 cmp2", d, 0);
    rd(A_STAT, d);   check("R9 stat", d, 0);
    check("R9 irq", {31'b0, irq}, 0);
    check("R9 pwm", {31'b0, pwm_out}, 0);

    // R1 R2: period grid
    for (int p = 0; p < 4; p++) begin
      for (int a = 1; a < 5; a++) begin
        wr(A_CTRL, 0);
        wr(A_PRESC, p);
        wr(A_RELOAD, a);
        wr(A_IEN, 1);
        wr(A_EVGEN, 1);
        wr(A_CTRL, 1);
        measure(per, narrow);
        check("R1 period", per, (p + 1) * (a + 1));
        check("R2 one-cycle pulse", {31'b0, narrow}, 1);
      end
    end

    // R1: prescaler keeps low 16 bits
    wr(A_CTRL, 0);
    wr(A_PRESC, 32'hABCD_0007);
    rd(A_PRESC, d); check("R1 presc width", d, 32'h7);

    // R6: rewriting divider / reload keeps the count
    wr(A_COUNT, 5);
    wr(A_PRESC, 0);
    rd(A_COUNT, d); check("R6 count after presc", d, 5);
    wr(A_RELOAD, 9);
    rd(A_COUNT, d); check("R6 count after reload", d, 5);
    check("R11 count write", d, 5);
    wr(A_IEN, 1);
    wr(A_CTRL, 1);
    per = 0;
    do begin @(negedge clk); per++; end while (!irq && per < 100);
    check("R6 first wrap from count", per, 9 - 5 + 1);

    // R2: gating by counter enable on a forced update
    wr(A_CTRL, 0);
    wr(A_STAT, 0);
    wr(A_EVGEN, 1);
    check("R2 no irq when stopped", {31'b0, irq}, 0);
    rd(A_STAT, d); check("R5 forced update sets flag", d, 1);
    wr(A_PRESC, 1000);
    wr(A_RELOAD, 100);
    wr(A_CTRL, 1);
    wr(A_EVGEN, 1);
    check("R2 irq on forced update", {31'b0, irq}, 1);
    @(negedge clk);
    check("R2 irq drops", {31'b0, irq}, 0);

    // R2: interrupt enable off
    wr(A_CTRL, 0);
    wr(A_PRESC, 0);
    wr(A_RELOAD, 2);
    wr(A_IEN, 0);
    wr(A_STAT, 0);
    wr(A_CTRL, 1);
    seen = 1'b0;
    repeat (20) begin @(negedge clk); if (irq) seen = 1'b1; end
    check("R2 no irq when disabled", {31'b0, seen}, 0);
    rd(A_STAT, d); check("R4 flag set without irq", d, 1);

    // R3: zero reload
    wr(A_CTRL, 0);
    wr(A_RELOAD, 0);
    wr(A_IEN, 1);
    wr(A_STAT, 0);
    wr(A_CTRL, 1);
    seen = 1'b0;
    repeat (50) begin @(negedge clk); if (irq) seen = 1'b1; end
    check("R3 no irq", {31'b0, seen}, 0);
    rd(A_STAT, d); check("R3 no flag", d, 0);

    // R4: write-one keeps, write-zero clears
    wr(A_CTRL, 0);
    wr(A_EVGEN, 1);
    wr(A_STAT, 1);
    rd(A_STAT, d); check("R4 write 1 keeps", d, 1);
    wr(A_STAT, 0);
    rd(A_STAT, d); check("R4 write 0 clears", d, 0);

    // R5: forced update restarts counter and prescaler
    wr(A_PRESC, 3);
    wr(A_RELOAD, 200);
    wr(A_CTRL, 1);
    repeat (30) @(negedge clk);
    wr(A_EVGEN, 1);
    rd(A_COUNT, d); check("R5 count zero", d, 0);
    repeat (3) @(negedge clk);
    rd(A_COUNT, d); check("R5 prescaler restarted", d, 0);
    @(negedge clk);
    rd(A_COUNT, d); check("R5 first tick", d, 1);
    rd(A_EVGEN, d); check("R5 evgen reads zero", d, 0);

    // R7: compare sweep in running mode
    wr(A_CTRL, 0);
    wr(A_PRESC, 0);
    wr(A_RELOAD, 7);
    wr(A_CHMA, (6 << 12) | (1 << 11));
    wr(A_CHEN, 1 << 4);
    for (int c = 0; c < 3; c++) begin
      int cv;
      cv = (c == 0) ? 3 : ((c == 1) ? 0 : 8);
      wr(A_CTRL, 0);
      wr(A_CMP2, cv);
      wr(A_EVGEN, 1);
      wr(A_CTRL, 1);
      for (int s = 0; s < 10; s++) begin
        @(negedge clk);
        rd(A_COUNT, d);
        check("R7 pwm vs count", {31'b0, pwm_out}, (d >= 32'(cv)) ? 1 : 0);
      end
    end

    // R7: mode field sweep
    wr(A_CTRL, 0);
    wr(A_CMP2, 3);
    wr(A_EVGEN, 1);
    wr(A_COUNT, 5);
    for (int m = 0; m < 8; m++) begin
      wr(A_CHMA, (m << 12) | (1 << 11));
      check("R7 mode gate", {31'b0, pwm_out},
            ((((m >> 2) & 1) | ((m >> 1) & 1)) & ~m & 1) ? 1 : 0);
    end
    wr(A_CHMA, (6 << 12));
    check("R7 preload off", {31'b0, pwm_out}, 0);
    wr(A_CHMA, (6 << 12) | (1 << 11));
    wr(A_CHEN, 0);
    check("R7 channel off", {31'b0, pwm_out}, 0);
    wr(A_CHEN, 1 << 4);
    check("R7 restored", {31'b0, pwm_out}, 1);

    // R8: preload of compare
    wr(A_CMP2, 9);
    rd(A_CMP2, d); check("R8 readback", d, 9);
    check("R8 old value still active", {31'b0, pwm_out}, 1);
    wr(A_EVGEN, 1);
    wr(A_COUNT, 5);
    check("R8 new value after update", {31'b0, pwm_out}, 0);

    // R10: unmapped offsets
    wr(A_RELOAD, 7);
    wr(14'h0030, 32'hFFFF_FFFF);
    wr(14'h0100, 32'hFFFF_FFFF);
    wr(14'h3FFC, 32'hFFFF_FFFF);
    rd(14'h0030, d); check("R10 gap reads zero", d, 0);
    rd(14'h0100, d); check("R10 high reads zero", d, 0);
    rd(14'h3FFC, d); check("R10 top reads zero", d, 0);
    rd(A_RELOAD, d); check("R10 reload untouched", d, 7);
    rd(A_COUNT, d);  check("R10 count untouched", d, 5);
    wr(A_EVGEN, 32'hFFFF_FFFE);
    rd(A_COUNT, d);  check("R5 evgen bit0 clear no effect", d, 5);

    finish_run();
  end
endmodule